// File: doc/BRIEF.md
# Sense-Reversing Centralized Barrier

This block lets up to sixteen agents meet at a common point before any of them moves on. Each agent pulses its arrive input once when it reaches the barrier. It then watches its release level, which falls when the arrival is accepted and rises again once every active agent has arrived. A single shared tally counts the arrivals of the current instance. When the tally reaches the configured agent count, one global phase bit flips and the tally clears. Each agent keeps a private phase bit that it toggles on every accepted arrival, and it is released whenever its own phase equals the global phase.

Because release compares phases rather than reading a count, the barrier can be reused back to back with no second counter. An agent that leaves one instance and arrives again at once holds its private phase opposite to the global phase. It therefore waits for the others of the new instance instead of slipping through.

Several arrivals in the same cycle are all counted in that cycle. An arrival that would break the protocol is dropped and raises a one-cycle error pulse. This covers an agent that is still waiting and an agent whose index lies outside the active count.

Top module: `sync_bar_core`

## Requirements
- R1: During and immediately after reset every release output is high, the error output is low and no arrivals are counted.
- R2: An accepted arrival from an agent that is not the last of its instance drives that agent's release low from the next cycle on, and it stays low until the instance completes.
- R3: In the cycle after the arrival that brings the tally to the active count, every release output is high and the tally starts again from zero.
- R4: All arrive pulses present in one cycle are counted together in that cycle, so a set of simultaneous arrivals can complete an instance on its own.
- R5: An agent that arrives again right after being released waits for the other agents of the new instance and is not released early.
- R6: An arrive pulse from an agent whose release is low is ignored (it does not advance the tally) and makes the error output high for exactly the next cycle.
- R7: An arrive pulse from an agent whose index is at or above the active count is ignored, leaves that agent's release high and makes the error output high in the next cycle.
- R8: The configured count is used as given from 1 to 16; a value of 0 acts as 1, and a value above 16 acts as 16. With a count of 1, every arrival of agent 0 completes at once, so its release never drops.
- R9: The active count follows the configuration input only while the tally is zero. A change made while arrivals are pending takes effect only after the current instance completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_parts | input | 5 | Requested number of agents taking part |
| arrive | input | 16 | One-cycle arrival pulse per agent |
| release_o | output | 16 | High when the agent is free to proceed |
| err_o | output | 1 | One-cycle pulse after an ignored arrival |

## Verification
The bench targets the reuse hazard: an agent re-arriving in the cycle after release must fall low. A design that reset the tally but kept phases in step would let it pass straight through. It drives a duplicate arrival from a waiting agent. A design that counted it would complete the instance one agent short, and one that did not flag it would leave err_o low. It also changes the count while arrivals are pending, and sends simultaneous arrivals mixed with out-of-range agents. A design that latched the count too eagerly, or summed the pulses wrongly, would release early or never release at all. Clamping at counts 0 and 20 checks that a single agent never drops its release and that a full sixteen-agent instance completes.

// File: rtl/sync_bar_pkg.sv
package sync_bar_pkg;

    // Map a raw requested agent count onto the legal range 1..maxp.
    function automatic int unsigned clamp_parts(input int unsigned raw,
                                                input int unsigned maxp);
        if (raw == 0)
            return 1;
        else if (raw > maxp)
            return maxp;
        else
            return raw;
    endfunction

endpackage

// File: rtl/sync_bar_filter.sv
// Screens arrive pulses: only agents inside the active count whose
// release is high may enter; any other pulse is rejected.
module sync_bar_filter #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = 5
) (
    input  logic [N-1:0]  arrive,
    input  logic [N-1:0]  sense_q,
    input  logic          flag_q,
    input  logic [CW-1:0] eff_parts,
    output logic [N-1:0]  valid,
    output logic          reject
);
    logic [N-1:0] member;
    logic [N-1:0] waiting;

    for (genvar gi = 0; gi < N; gi++) begin : g_agent
        assign member[gi]  = (CW'(gi) < eff_parts);
        assign waiting[gi] = sense_q[gi] ^ flag_q;
        assign valid[gi]   = arrive[gi] & member[gi] & ~waiting[gi];
    end

    assign reject = |(arrive & ~valid);
endmodule

// File: rtl/sync_bar_tally.sv
// Adds all accepted arrivals of one cycle to the shared tally and
// detects the completing cycle.
module sync_bar_tally #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = 5
) (
    input  logic [N-1:0]  valid,
    input  logic [CW-1:0] count_q,
    input  logic [CW-1:0] eff_parts,
    output logic [CW-1:0] count_next,
    output logic          done
);
    logic [CW-1:0] pop;
    logic [CW:0]   sum;

    always_comb begin
        pop = '0;
        for (int i = 0; i < N; i++)
            pop = pop + CW'(valid[i]);
    end

    assign sum        = {1'b0, count_q} + {1'b0, pop};
    assign done       = (pop != '0) && (sum == {1'b0, eff_parts});
    assign count_next = done ? '0 : sum[CW-1:0];
endmodule

// File: rtl/sync_bar_core.sv
module sync_bar_core #(
    parameter  int unsigned MAX_PARTS = 16,
    localparam int unsigned CW        = $clog2(MAX_PARTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cfg_parts,
    input  logic [MAX_PARTS-1:0] arrive,
    output logic [MAX_PARTS-1:0] release_o,
    output logic                 err_o
);
    import sync_bar_pkg::*;

    typedef struct packed {
        logic [MAX_PARTS-1:0] sense;
        logic                 flag;
        logic [CW-1:0]        count;
        logic [CW-1:0]        parts;
        logic                 err;
    } state_t;

    state_t st_q, st_d;

    logic [CW-1:0]        cfg_clamped;
    logic [CW-1:0]        eff_parts;
    logic [MAX_PARTS-1:0] valid;
    logic                 reject;
    logic [CW-1:0]        count_next;
    logic                 done;

    assign cfg_clamped = CW'(clamp_parts(32'(cfg_parts), MAX_PARTS));
    // The count may only move while no instance is in progress.
    assign eff_parts   = (st_q.count == '0) ? cfg_clamped : st_q.parts;

    sync_bar_filter #(.N(MAX_PARTS), .CW(CW)) u_filter (
        .arrive    (arrive),
        .sense_q   (st_q.sense),
        .flag_q    (st_q.flag),
        .eff_parts (eff_parts),
        .valid     (valid),
        .reject    (reject)
    );

    sync_bar_tally #(.N(MAX_PARTS), .CW(CW)) u_tally (
        .valid      (valid),
        .count_q    (st_q.count),
        .eff_parts  (eff_parts),
        .count_next (count_next),
        .done       (done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.parts = eff_parts;
        st_d.err   = reject;
        if (done) begin
            // Flip the global phase; every agent, active or not, ends
            // the instance with its phase equal to the new global one.
            st_d.flag  = ~st_q.flag;
            st_d.count = '0;
            st_d.sense = {MAX_PARTS{~st_q.flag}};
        end else begin
            st_d.sense = st_q.sense ^ valid;
            st_d.count = count_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sense <= '0;
            st_q.flag  <= 1'b0;
            st_q.count <= '0;
            st_q.parts <= CW'(1);
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign release_o = ~(st_q.sense ^ {MAX_PARTS{st_q.flag}});
    assign err_o     = st_q.err;
endmodule

// File: rtl/sync_bar_checker.sv
module sync_bar_checker #(
    parameter  int unsigned MAX_PARTS = 16,
    localparam int unsigned CW        = $clog2(MAX_PARTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MAX_PARTS-1:0] arrive,
    input logic [MAX_PARTS-1:0] release_o,
    input logic                 err_o,
    input logic [CW-1:0]        count_q,
    input logic                 flag_q
);
    // An empty tally means nobody is held.
    assert_idle_all_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> (&release_o));

    // A held agent stays held until the global phase moves.
    for (genvar gi = 0; gi < MAX_PARTS; gi++) begin : g_hold
        assert_wait_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !release_o[gi] |=> (!release_o[gi] || !$stable(flag_q)));
    end

    // The phase only flips together with a cleared tally.
    assert_flip_clears_tally_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_q) |-> (count_q == '0));

    // Arrival from a held agent is reported one cycle later.
    assert_dup_flags_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(arrive & ~release_o)) |=> err_o);

    // The tally never reaches the largest count without completing.
    assert_tally_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(MAX_PARTS - 1));
endmodule

bind sync_bar_core sync_bar_checker #(.MAX_PARTS(MAX_PARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive    (arrive),
    .release_o (release_o),
    .err_o     (err_o),
    .count_q   (st_q.count),
    .flag_q    (st_q.flag)
);

// File: tb/tb_sync_bar_core.sv
module tb_sync_bar_core;
    localparam int N  = 16;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_parts = 5'd4;
    logic [N-1:0]  arrive = '0;
    logic [N-1:0]  release_o;
    logic          err_o;

    always #5 clk = ~clk;

    sync_bar_core #(.MAX_PARTS(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_parts (cfg_parts),
        .arrive    (arrive),
        .release_o (release_o),
        .err_o     (err_o)
    );

    typedef struct {
        logic [N-1:0] rel;
        logic         err;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // Requirement-level model of the barrier.
    int           m_cnt = 0;
    int           m_parts = 1;
    logic [N-1:0] m_wait = '0;

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic step(input logic [N-1:0] arr, input logic [CW-1:0] cfg,
                        input string tag);
        exp_t e;
        logic [N-1:0] acc;
        int pop;
        @(negedge clk);
        arrive    = arr;
        cfg_parts = cfg;
        if (m_cnt == 0)
            m_parts = (cfg == 0) ? 1 : ((int'(cfg) > N) ? N : int'(cfg));
        acc = '0;
        pop = 0;
        for (int i = 0; i < N; i++) begin
            if (arr[i] && i < m_parts && !m_wait[i]) begin
                acc[i] = 1'b1;
                pop++;
            end
        end
        e.err = ((arr & ~acc) != '0);
        m_cnt += pop;
        if (m_cnt == m_parts) begin
            m_cnt  = 0;
            m_wait = '0;
        end else begin
            m_wait |= acc;
        end
        e.rel = ~m_wait;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each expected item just after the edge it belongs to.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            checks++;
            if (release_o !== mon_e.rel || err_o !== mon_e.err) begin
                errors++;
                $display("FAIL %s: release=%h err=%b expected release=%h err=%b",
                         mon_e.tag, release_o, err_o, mon_e.rel, mon_e.err);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !finished) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (release_o !== {N{1'b1}} || err_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: release=%h err=%b expected release=%h err=0",
                     release_o, err_o, {N{1'b1}});
        end
        rst_n = 1'b1;
        step(16'h0000, 5'd4, "R1 idle after reset");

        step(16'h0001, 5'd4, "R2 first arrival waits");
        step(16'h0000, 5'd4, "R2 waiting holds");
        step(16'h0002, 5'd4, "R2 second arrival waits");
        step(16'h0001, 5'd4, "R6 duplicate from waiting agent");
        step(16'h0000, 5'd4, "R6 duplicate not counted");
        step(16'h0004, 5'd4, "R2 third arrival waits");
        step(16'h0008, 5'd4, "R3 last arrival releases all");

        step(16'h000F, 5'd4, "R4 simultaneous full set");
        step(16'h0003, 5'd4, "R4 simultaneous pair waits");
        step(16'h000C, 5'd4, "R3 pair completes instance");
        step(16'h0001, 5'd4, "R5 re-entry after release waits");
        step(16'h000E, 5'd4, "R5 next instance completes");

        step(16'h0100, 5'd4, "R7 outside agent ignored");
        step(16'h0011, 5'd4, "R7 mixed inside and outside");
        step(16'h000E, 5'd4, "R7 instance completes");

        step(16'h0001, 5'd0, "R8 count zero acts as one");
        step(16'h0001, 5'd0, "R8 single agent repeats");
        step(16'h0002, 5'd0, "R8 agent one outside single count");
        step(16'hFFFF, 5'd20, "R8 count clamps to sixteen");
        step(16'h7FFF, 5'd20, "R8 fifteen of sixteen wait");
        step(16'h8000, 5'd20, "R8 sixteenth completes");

        step(16'h0001, 5'd3, "R9 first of three");
        step(16'h0002, 5'd2, "R9 count change while pending ignored");
        step(16'h0000, 5'd2, "R9 still waiting");
        step(16'h0004, 5'd2, "R9 completes with old count");
        step(16'h0003, 5'd2, "R9 new count takes effect");
        step(16'h0000, 5'd2, "R1 idle at end");

        @(posedge clk);
        @(posedge clk);
        #2;
        finish_run();
    end
endmodule